// File: doc/BRIEF.md
# DDR SDRAM Command Bus Protocol Monitor

This block watches the command pins of a registered DDR SDRAM interface without driving anything. Every clock it samples clock enable, chip select, the three strobe pins, the bank address, address bit 10 and the low three address bits. It turns the pin pattern into a command code and follows an open or closed state for each of four banks. It also flags commands that are not allowed in the current bank state, and commands that arrive too soon after an earlier command under one of the minimum-spacing rules.

All minimum spacings are parameters counted in clock cycles. The defaults suit a 7.5 ns clock. Every bank keeps its own down-counters. A column command with auto precharge closes its bank once the burst has ended. The burst length for that is taken from the last mode register write. Every error class owns one sticky bit, which stays set until a synchronous clear.

Top module: `ddr_cmd_checker`

## Requirements
- R1: The command is decoded only while cke_i is high and cs_n_i is low. With {ras_n,cas_n,we_n} = 000 it is mode set (code 1), 001 refresh (2), 011 activate (3), 101 read (4), 100 write (5), 110 burst stop (6), 010 precharge (7), and 111 no operation (0). When cke_i is low or cs_n_i is high the code is 0. cmd_o shows the code one cycle after the command is sampled.
- R2: bank_open_o bit i stands for bank i, with ba_i = 0..3 selecting banks 0..3. An activate sets the bit of the selected bank. A precharge with a10_i low clears the bit of the selected bank. A precharge with a10_i high clears every bit and ignores ba_i.
- R3: err_o[0] is set by a read or write to a closed bank, and by an activate to a bank that is already open.
- R4: err_o[1] is set by a mode set or a refresh while any bank is open.
- R5: err_o[2] is set by any command other than no operation that comes less than T_MRD (default 2) cycles after a mode set.
- R6: err_o[3] is set by a read or write that comes less than T_RCD (default 3) cycles after the activate of that bank.
- R7: err_o[4] is set by an activate that comes less than T_RP (default 3) cycles after that bank closed, whether the close came from an explicit precharge or from an auto precharge.
- R8: err_o[5] is set by a precharge of an open bank that comes less than T_RAS (default 6) cycles after that bank's activate.
- R9: err_o[6] is set by an activate that comes less than T_RRD (default 2) cycles after an activate to a different bank.
- R10: err_o[7] is set by an activate that comes less than T_RC (default 9) cycles after the previous activate of the same bank. A gap of exactly T_RC is legal.
- R11: A read or write to an open bank with a10_i high closes that bank exactly BL/2 cycles after the column command. BL is captured at each mode set from mode_bl_i: 001 gives 2, 010 gives 4, 011 gives 8, and any other code keeps the previous value. After reset BL is 8.
- R12: err_o[8] is set by a read or write issued while a write burst with auto precharge is still running, meaning fewer than BL/2 cycles after that write.
- R13: Error bits stay set until clr_i is high for one cycle, which clears them. Reset clears the error bits, closes all banks and sets cmd_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the error bits |
| cke_i | input | 1 | Sampled clock enable |
| cs_n_i | input | 1 | Sampled chip select, active low |
| ras_n_i | input | 1 | Sampled row strobe, active low |
| cas_n_i | input | 1 | Sampled column strobe, active low |
| we_n_i | input | 1 | Sampled write enable, active low |
| ba_i | input | 2 | Sampled bank address |
| a10_i | input | 1 | Sampled address bit 10 (all-bank / auto precharge) |
| mode_bl_i | input | 3 | Sampled address bits 2..0, the burst length code at mode set |
| cmd_o | output | 3 | Decoded command code |
| bank_open_o | output | 4 | Open status per bank |
| err_o | output | 9 | Sticky error bits, one per rule class |

## Verification
All three outputs are registered, so each shows the effect of a command one edge after the edge that sampled it. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, which is exactly one cycle later. A spacing rule is tested at the cycle count that is one short of its minimum, where an error is due, and at the count that meets it exactly, where none is due. An auto precharge close is due BL/2 cycles after its column command, so the bench reads bank_open_o in that cycle and in the cycle before it.

// File: rtl/ddrchk_pkg.sv
package ddrchk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_MRS = 3'd1,
    CMD_REF = 3'd2,
    CMD_ACT = 3'd3,
    CMD_RD  = 3'd4,
    CMD_WR  = 3'd5,
    CMD_BST = 3'd6,
    CMD_PRE = 3'd7
  } ddr_cmd_e;

  localparam int ERR_W     = 9;
  localparam int ERR_STATE = 0;
  localparam int ERR_IDLE  = 1;
  localparam int ERR_MRD   = 2;
  localparam int ERR_RCD   = 3;
  localparam int ERR_RP    = 4;
  localparam int ERR_RAS   = 5;
  localparam int ERR_RRD   = 6;
  localparam int ERR_RC    = 7;
  localparam int ERR_WAP   = 8;

  localparam int BLH_W = 3;

endpackage

// File: rtl/ddrchk_decode.sv
module ddrchk_decode
  import ddrchk_pkg::*;
(
  input  logic     cke_i,
  input  logic     cs_n_i,
  input  logic     ras_n_i,
  input  logic     cas_n_i,
  input  logic     we_n_i,
  output ddr_cmd_e cmd_o
);

  always_comb begin
    cmd_o = CMD_NOP;
    if (cke_i && !cs_n_i) begin
      case ({ras_n_i, cas_n_i, we_n_i})
        3'b000:  cmd_o = CMD_MRS;
        3'b001:  cmd_o = CMD_REF;
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b110:  cmd_o = CMD_BST;
        3'b010:  cmd_o = CMD_PRE;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddrchk_dncnt.sv
module ddrchk_dncnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         busy_o
);

  logic [W-1:0] cnt_q, cnt_n;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    if (load_i) cnt_n = load_val_i;
    else        cnt_n = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/ddrchk_bank.sv
module ddrchk_bank
  import ddrchk_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 6,
  parameter int T_RC  = 9,
  parameter int CW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             col_i,
  input  logic             col_ap_i,
  input  logic             col_wr_i,
  input  logic [BLH_W-1:0] bl_half_i,
  output logic             open_o,
  output logic             rcd_busy_o,
  output logic             rp_busy_o,
  output logic             ras_busy_o,
  output logic             rc_busy_o,
  output logic             wap_busy_o
);

  localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] LD_RAS = CW'(T_RAS - 1);
  localparam logic [CW-1:0] LD_RC  = CW'(T_RC - 1);

  logic open_q, open_n;
  logic pend_q, pend_n;
  logic pend_wr_q, pend_wr_n;
  logic ap_busy, ap_load, fire, close, rp_load;

  assign fire    = pend_q && !ap_busy;
  assign close   = (pre_i && open_q) || fire;
  assign ap_load = col_i && col_ap_i && open_q && !close && !act_i;
  assign rp_load = close;

  ddrchk_dncnt #(.W(CW)) u_rcd (.clk(clk), .rst_n(rst_n), .load_i(act_i),
                                .load_val_i(LD_RCD), .busy_o(rcd_busy_o));
  ddrchk_dncnt #(.W(CW)) u_ras (.clk(clk), .rst_n(rst_n), .load_i(act_i),
                                .load_val_i(LD_RAS), .busy_o(ras_busy_o));
  ddrchk_dncnt #(.W(CW)) u_rc  (.clk(clk), .rst_n(rst_n), .load_i(act_i),
                                .load_val_i(LD_RC), .busy_o(rc_busy_o));
  ddrchk_dncnt #(.W(CW)) u_rp  (.clk(clk), .rst_n(rst_n), .load_i(rp_load),
                                .load_val_i(LD_RP), .busy_o(rp_busy_o));
  ddrchk_dncnt #(.W(BLH_W)) u_ap (.clk(clk), .rst_n(rst_n), .load_i(ap_load),
                                  .load_val_i(bl_half_i - BLH_W'(1)),
                                  .busy_o(ap_busy));

  always_comb begin
    open_n    = open_q;
    pend_n    = pend_q;
    pend_wr_n = pend_wr_q;
    if (act_i)      open_n = 1'b1;
    else if (close) open_n = 1'b0;
    if (act_i || close) pend_n = 1'b0;
    else if (ap_load)   pend_n = 1'b1;
    if (ap_load) pend_wr_n = col_wr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      pend_q    <= 1'b0;
      pend_wr_q <= 1'b0;
    end else begin
      open_q    <= open_n;
      pend_q    <= pend_n;
      pend_wr_q <= pend_wr_n;
    end
  end

  assign open_o     = open_q;
  assign wap_busy_o = pend_q && pend_wr_q && ap_busy;

endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker
  import ddrchk_pkg::*;
#(
  parameter int N_BANK = 4,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_RAS  = 6,
  parameter int T_RRD  = 2,
  parameter int T_RC   = 9,
  parameter int T_MRD  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              cke_i,
  input  logic              cs_n_i,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [1:0]        ba_i,
  input  logic              a10_i,
  input  logic [2:0]        mode_bl_i,
  output logic [2:0]        cmd_o,
  output logic [N_BANK-1:0] bank_open_o,
  output logic [ERR_W-1:0]  err_o
);

  localparam int BA_W = $clog2(N_BANK);
  localparam int TM1  = (T_RCD > T_RP)  ? T_RCD : T_RP;
  localparam int TM2  = (TM1 > T_RAS)   ? TM1   : T_RAS;
  localparam int TM3  = (TM2 > T_RRD)   ? TM2   : T_RRD;
  localparam int TM4  = (TM3 > T_RC)    ? TM3   : T_RC;
  localparam int TMAX = (TM4 > T_MRD)   ? TM4   : T_MRD;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] LD_RRD = CW'(T_RRD - 1);
  localparam logic [CW-1:0] LD_MRD = CW'(T_MRD - 1);

  ddr_cmd_e cmd;
  logic is_act, is_pre, is_col, is_wr, is_mrs, is_ref;

  ddrchk_decode u_dec (
    .cke_i(cke_i), .cs_n_i(cs_n_i), .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i), .we_n_i(we_n_i), .cmd_o(cmd)
  );

  assign is_act = (cmd == CMD_ACT);
  assign is_pre = (cmd == CMD_PRE);
  assign is_wr  = (cmd == CMD_WR);
  assign is_col = (cmd == CMD_RD) || is_wr;
  assign is_mrs = (cmd == CMD_MRS);
  assign is_ref = (cmd == CMD_REF);

  // burst length register (stores BL/2)
  logic [BLH_W-1:0] blh_q, blh_n;
  logic             blh_en;

  always_comb begin
    blh_en = 1'b0;
    blh_n  = blh_q;
    if (is_mrs) begin
      case (mode_bl_i)
        3'b001:  begin blh_n = BLH_W'(1); blh_en = 1'b1; end
        3'b010:  begin blh_n = BLH_W'(2); blh_en = 1'b1; end
        3'b011:  begin blh_n = BLH_W'(4); blh_en = 1'b1; end
        default: blh_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blh_q <= BLH_W'(4);
    else if (blh_en) blh_q <= blh_n;
  end

  // per-bank trackers
  logic [N_BANK-1:0] open_v, rcd_b, rp_b, ras_b, rc_b, wap_b;
  logic [N_BANK-1:0] sel;

  for (genvar g = 0; g < N_BANK; g++) begin : g_bank
    assign sel[g] = (ba_i[BA_W-1:0] == BA_W'(g));
    ddrchk_bank #(
      .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC), .CW(CW)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .act_i(is_act && sel[g]),
      .pre_i(is_pre && (a10_i || sel[g])),
      .col_i(is_col && sel[g]),
      .col_ap_i(a10_i),
      .col_wr_i(is_wr),
      .bl_half_i(blh_q),
      .open_o(open_v[g]),
      .rcd_busy_o(rcd_b[g]),
      .rp_busy_o(rp_b[g]),
      .ras_busy_o(ras_b[g]),
      .rc_busy_o(rc_b[g]),
      .wap_busy_o(wap_b[g])
    );
  end

  // shared spacing timers
  logic rrd_busy, mrd_busy;
  logic [1:0] last_ba_q;

  ddrchk_dncnt #(.W(CW)) u_rrd (.clk(clk), .rst_n(rst_n), .load_i(is_act),
                                .load_val_i(LD_RRD), .busy_o(rrd_busy));
  ddrchk_dncnt #(.W(CW)) u_mrd (.clk(clk), .rst_n(rst_n), .load_i(is_mrs),
                                .load_val_i(LD_MRD), .busy_o(mrd_busy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_ba_q <= 2'b00;
    else if (is_act) last_ba_q <= ba_i;
  end

  // rule evaluation
  logic [ERR_W-1:0] err_new, err_q, err_n;
  logic             sel_open;

  assign sel_open = |(open_v & sel);

  always_comb begin
    err_new            = '0;
    err_new[ERR_STATE] = (is_act && sel_open) || (is_col && !sel_open);
    err_new[ERR_IDLE]  = (is_mrs || is_ref) && (|open_v);
    err_new[ERR_MRD]   = (cmd != CMD_NOP) && mrd_busy;
    err_new[ERR_RCD]   = is_col && (|(rcd_b & sel));
    err_new[ERR_RP]    = is_act && (|(rp_b & sel));
    err_new[ERR_RAS]   = is_pre && (a10_i ? (|(ras_b & open_v))
                                          : (|(ras_b & open_v & sel)));
    err_new[ERR_RRD]   = is_act && rrd_busy && (ba_i != last_ba_q);
    err_new[ERR_RC]    = is_act && (|(rc_b & sel));
    err_new[ERR_WAP]   = is_col && (|wap_b);
    err_n = clr_i ? err_new : (err_q | err_new);
  end

  ddr_cmd_e cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      cmd_q <= CMD_NOP;
    end else begin
      err_q <= err_n;
      cmd_q <= cmd;
    end
  end

  assign cmd_o       = cmd_q;
  assign bank_open_o = open_v;
  assign err_o       = err_q;

endmodule

// File: rtl/ddr_cmd_checker_sva.sv
module ddr_cmd_checker_sva #(
  parameter int N_BANK = 4,
  parameter int EW     = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_i,
  input logic              cke_i,
  input logic              cs_n_i,
  input logic              ras_n_i,
  input logic              cas_n_i,
  input logic              we_n_i,
  input logic [1:0]        ba_i,
  input logic              a10_i,
  input logic [2:0]        cmd_o,
  input logic [N_BANK-1:0] bank_open_o,
  input logic [EW-1:0]     err_o
);

  logic act_in, pre_all_in, idle_req_in;

  assign act_in      = cke_i && !cs_n_i && !ras_n_i && cas_n_i && we_n_i;
  assign pre_all_in  = cke_i && !cs_n_i && !ras_n_i && cas_n_i && !we_n_i && a10_i;
  assign idle_req_in = cke_i && !cs_n_i && !ras_n_i && !cas_n_i;

  p_deselect_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> (cmd_o == 3'd0));

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_in |=> bank_open_o[$past(ba_i)]);

  p_pre_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_all_in && !act_in) |=> (bank_open_o == '0));

  p_idle_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o[1]) |-> $past(idle_req_in));

  p_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((err_o & $past(err_o)) == $past(err_o)));

endmodule

bind ddr_cmd_checker ddr_cmd_checker_sva #(.N_BANK(N_BANK), .EW(ddrchk_pkg::ERR_W)) u_sva (.*);

// File: tb/ddr_cmd_checker_test.sv
`timescale 1ns/1ps
module ddr_cmd_checker_test;

  localparam logic [2:0] NOP = 3'd0, MRS = 3'd1, REF = 3'd2, ACT = 3'd3,
                         RD = 3'd4, WR = 3'd5, BST = 3'd6, PRE = 3'd7;
  localparam logic [8:0] E_ST = 9'h001, E_ID = 9'h002, E_MRD = 9'h004,
                         E_RCD = 9'h008, E_RP = 9'h010, E_RAS = 9'h020,
                         E_RRD = 9'h040, E_RC = 9'h080, E_WAP = 9'h100;

  // {cmd, ba, a10, bl, exp_open, exp_err}
  localparam int NV = 15;
  localparam logic [21:0] TBL [NV] = '{
    {MRS, 2'd0, 1'b0, 3'b010, 4'b0000, 9'h000},
    {NOP, 2'd0, 1'b0, 3'b000, 4'b0000, 9'h000},
    {ACT, 2'd0, 1'b0, 3'b000, 4'b0001, 9'h000},
    {NOP, 2'd0, 1'b0, 3'b000, 4'b0001, 9'h000},
    {ACT, 2'd1, 1'b0, 3'b000, 4'b0011, 9'h000},
    {WR,  2'd0, 1'b0, 3'b000, 4'b0011, 9'h000},
    {NOP, 2'd0, 1'b0, 3'b000, 4'b0011, 9'h000},
    {RD,  2'd1, 1'b1, 3'b000, 4'b0011, 9'h000},
    {PRE, 2'd0, 1'b0, 3'b000, 4'b0010, 9'h000},
    {NOP, 2'd0, 1'b0, 3'b000, 4'b0000, 9'h000},
    {BST, 2'd0, 1'b0, 3'b000, 4'b0000, 9'h000},
    {ACT, 2'd0, 1'b0, 3'b000, 4'b0001, 9'h000},
    {NOP, 2'd0, 1'b0, 3'b000, 4'b0001, 9'h000},
    {ACT, 2'd1, 1'b0, 3'b000, 4'b0011, 9'h000},
    {REF, 2'd0, 1'b0, 3'b000, 4'b0011, 9'h002}
  };

  logic clk, rst_n, clr_i, cke_i, cs_n_i, ras_n_i, cas_n_i, we_n_i, a10_i;
  logic [1:0] ba_i;
  logic [2:0] mode_bl_i, cmd_o;
  logic [3:0] bank_open_o;
  logic [8:0] err_o;
  int n_chk, n_fail;

  ddr_cmd_checker uut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #(100000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic check(input string r, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic raw(input logic ck, input logic cs, input logic [2:0] pins,
                     input logic [1:0] b, input logic a10, input logic [2:0] bl);
    cke_i = ck; cs_n_i = cs; {ras_n_i, cas_n_i, we_n_i} = pins;
    ba_i = b; a10_i = a10; mode_bl_i = bl;
    @(negedge clk);
  endtask

  function automatic logic [2:0] enc(input logic [2:0] c);
    case (c)
      MRS: return 3'b000;
      REF: return 3'b001;
      ACT: return 3'b011;
      RD:  return 3'b101;
      WR:  return 3'b100;
      BST: return 3'b110;
      PRE: return 3'b010;
      default: return 3'b111;
    endcase
  endfunction

  task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic a10,
                       input logic [2:0] bl = 3'b000);
    raw(1'b1, 1'b0, enc(c), b, a10, bl);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(NOP, 2'd0, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; clr_i = 1'b0;
    cke_i = 1'b1; cs_n_i = 1'b0; {ras_n_i, cas_n_i, we_n_i} = 3'b111;
    ba_i = 2'd0; a10_i = 1'b0; mode_bl_i = 3'b000;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    do_reset();
    check("R13 reset cmd", 16'(cmd_o), 16'd0);
    check("R13 reset open", 16'(bank_open_o), 16'd0);
    check("R13 reset err", 16'(err_o), 16'd0);

    // table walk: R1 decode, R2 open tracking, R11 BL4 auto precharge, R4 refresh
    for (int i = 0; i < NV; i++) begin
      issue(TBL[i][21:19], TBL[i][18:17], TBL[i][16], TBL[i][15:13]);
      check($sformatf("R1 vec %0d cmd", i), 16'(cmd_o), 16'(TBL[i][21:19]));
      check($sformatf("R2 R11 vec %0d open", i), 16'(bank_open_o), 16'(TBL[i][12:9]));
      check($sformatf("R4 vec %0d err", i), 16'(err_o), 16'(TBL[i][8:0]));
    end

    // R13 clear
    clr_i = 1'b1; idle(1); clr_i = 1'b0;
    check("R13 clear", 16'(err_o), 16'd0);
    check("R13 clear keeps banks", 16'(bank_open_o), 16'b0011);

    // R1 deselect and clock enable low ignore the pins
    do_reset();
    raw(1'b1, 1'b1, 3'b011, 2'd0, 1'b0, 3'b000);
    check("R1 deselect cmd", 16'(cmd_o), 16'd0);
    check("R1 deselect open", 16'(bank_open_o), 16'd0);
    raw(1'b0, 1'b0, 3'b011, 2'd0, 1'b0, 3'b000);
    check("R1 cke low cmd", 16'(cmd_o), 16'd0);
    check("R1 cke low open", 16'(bank_open_o), 16'd0);

    // R3 state errors
    do_reset();
    issue(RD, 2'd2, 1'b0);
    check("R3 read idle bank", 16'(err_o), 16'(E_ST));
    clr_i = 1'b1; idle(1); clr_i = 1'b0;
    issue(ACT, 2'd3, 1'b0); idle(3); issue(ACT, 2'd3, 1'b0);
    check("R3 activate open bank", 16'(err_o), 16'(E_ST | E_RC));

    // R5 mode set spacing
    do_reset();
    issue(MRS, 2'd0, 1'b0, 3'b011); issue(ACT, 2'd0, 1'b0);
    check("R5 mrd", 16'(err_o), 16'(E_MRD));

    // R6 rcd
    do_reset();
    issue(ACT, 2'd0, 1'b0); idle(1); issue(RD, 2'd0, 1'b0);
    check("R6 rcd", 16'(err_o), 16'(E_RCD));

    // R7 rp (also R10 rc short)
    do_reset();
    issue(ACT, 2'd0, 1'b0); idle(5); issue(PRE, 2'd0, 1'b0); idle(1); issue(ACT, 2'd0, 1'b0);
    check("R7 rp", 16'(err_o), 16'(E_RP | E_RC));

    // R10 rc met exactly
    do_reset();
    issue(ACT, 2'd0, 1'b0); idle(5); issue(PRE, 2'd0, 1'b0); idle(2); issue(ACT, 2'd0, 1'b0);
    check("R10 rc boundary", 16'(err_o), 16'd0);
    check("R10 reopened", 16'(bank_open_o), 16'b0001);

    // R8 ras
    do_reset();
    issue(ACT, 2'd0, 1'b0); idle(4); issue(PRE, 2'd0, 1'b0);
    check("R8 ras", 16'(err_o), 16'(E_RAS));
    check("R8 closed", 16'(bank_open_o), 16'd0);

    // R9 rrd, then R13 sticky
    do_reset();
    issue(ACT, 2'd0, 1'b0); issue(ACT, 2'd1, 1'b0);
    check("R9 rrd", 16'(err_o), 16'(E_RRD));
    idle(2);
    check("R13 sticky", 16'(err_o), 16'(E_RRD));

    // R2 precharge all ignores ba
    do_reset();
    issue(ACT, 2'd0, 1'b0); idle(1); issue(ACT, 2'd2, 1'b0); idle(5);
    check("R2 two open", 16'(bank_open_o), 16'b0101);
    issue(PRE, 2'd1, 1'b1);
    check("R2 precharge all", 16'(bank_open_o), 16'd0);
    check("R2 precharge all err", 16'(err_o), 16'd0);

    // R11 and R7: write auto precharge at default BL8, legal sequence
    do_reset();
    issue(ACT, 2'd0, 1'b0); idle(1); issue(ACT, 2'd1, 1'b0);
    issue(WR, 2'd0, 1'b1); idle(3);
    check("R11 open before burst end", 16'(bank_open_o), 16'b0011);
    issue(RD, 2'd1, 1'b0);
    check("R12 read at burst end", 16'(err_o), 16'd0);
    check("R11 closed at burst end", 16'(bank_open_o), 16'b0010);
    idle(2); issue(ACT, 2'd0, 1'b0);
    check("R7 rp after auto precharge", 16'(err_o), 16'd0);

    // R12 column command inside write auto precharge burst
    do_reset();
    issue(ACT, 2'd0, 1'b0); idle(1); issue(ACT, 2'd1, 1'b0);
    issue(WR, 2'd0, 1'b1); idle(2); issue(RD, 2'd1, 1'b0);
    check("R12 wap", 16'(err_o), 16'(E_WAP));

    // R7 activate too soon after auto precharge close
    do_reset();
    issue(ACT, 2'd0, 1'b0); idle(2); issue(RD, 2'd0, 1'b1); idle(3);
    issue(NOP, 2'd0, 1'b0); idle(1); issue(ACT, 2'd0, 1'b0);
    check("R7 rp after auto close", 16'(err_o) & 16'(E_RP), 16'(E_RP));

    // R11 BL2 captured
    do_reset();
    issue(MRS, 2'd0, 1'b0, 3'b001); idle(1); issue(ACT, 2'd0, 1'b0); idle(2);
    issue(RD, 2'd0, 1'b1);
    check("R11 bl2 open at column", 16'(bank_open_o), 16'b0001);
    idle(1);
    check("R11 bl2 closed", 16'(bank_open_o), 16'd0);

    // R11 unknown code keeps BL8
    do_reset();
    issue(MRS, 2'd0, 1'b0, 3'b111); idle(1); issue(ACT, 2'd0, 1'b0); idle(2);
    issue(RD, 2'd0, 1'b1); idle(3);
    check("R11 kept bl8 still open", 16'(bank_open_o), 16'b0001);
    idle(1);
    check("R11 kept bl8 closed", 16'(bank_open_o), 16'd0);
    check("R11 no errors", 16'(err_o), 16'd0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule